// File: doc/BRIEF.md
# Rotate, Shift and Nibble-Rotate Unit

This unit computes the byte-wide rotate and shift operations of an 8-bit processor datapath, and the flags they produce. A single 4-bit select chooses the operation. The first eight codes are the full rotate and shift forms, which work on a general operand. Four codes are the short accumulator rotates. The last two are the nibble rotates, which shuffle half-bytes between the accumulator and a memory byte. The undocumented shift-left that inserts a one is included.

The surrounding core decodes the instruction and fetches the operand. It then presents the operation, the operand, the accumulator and the current flag byte with a valid strobe. One clock later the unit returns three registered values:
- the primary result (the new operand, or the new accumulator),
- a secondary result (the byte to write back to memory for the nibble rotates),
- the new flag byte.

Memory sequencing and prefix decoding stay in the core.

Top module: `rot_shift_unit`

## Requirements
- R1: Codes 0 to 3 rotate `operand`. Code 0 rotates left, with bit 7 going to both carry and bit 0. Code 1 rotates right, with bit 0 going to both carry and bit 7. Code 2 rotates left through the incoming carry. Code 3 rotates right through the incoming carry.
- R2: Codes 4 to 7 shift `operand`. Code 4 shifts left and inserts 0. Code 5 shifts right and keeps bit 7. Code 6 shifts left and inserts 1. Code 7 shifts right and inserts 0. The bit shifted out goes to carry.
- R3: The flag byte layout is S=bit 7, Z=6, copy-5=5, H=4, copy-3=3, P/V=2, N=1, C=0. For codes 0 to 7, S, copy-5 and copy-3 are taken from the result. Z is set when the result is zero. P/V is set when the result has an even number of ones. H and N are cleared.
- R4: Codes 8 to 11 apply the code 0 to 3 operations to `acc` instead of `operand`. They update only copy-5, copy-3 and C, clear H and N, and pass S, Z and P/V through from `flags_in`.
- R5: Code 12 is the left nibble rotate. With `acc` = pq and `operand` = rs, `result` = pr and `mem_result` = sq.
- R6: Code 13 is the right nibble rotate. With `acc` = pq and `operand` = rs, `result` = ps and `mem_result` = qr.
- R7: For codes 12 and 13, S, copy-5, copy-3 and Z come from the new accumulator, and P/V is set when the new accumulator has even parity. H and N are cleared, and C is passed through from `flags_in`.
- R8: Codes 14 and 15 are pass-through: `result` = `operand` and `flags_out` = `flags_in`. For every code other than 12 and 13, `mem_result` equals `operand`.
- R9: The outputs change only at the clock edge that samples `in_valid` high, and `out_valid` is high in the cycle after. With `in_valid` low, all outputs hold their values.
- R10: Synchronous active-low reset clears `out_valid`, `result`, `mem_result` and `flags_out` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| op_sel | input | 4 | Operation select |
| operand | input | 8 | Operand or memory byte |
| acc | input | 8 | Accumulator |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Registered results are new |
| result | output | 8 | Primary result (new operand or new accumulator) |
| mem_result | output | 8 | Memory write-back byte |
| flags_out | output | 8 | New flag byte |

## Verification
The assertions assume that the core holds the inputs steady around each rising edge. They also assume that a valid strobe comes with a defined select. Any of the sixteen codes is legal, so the properties do not restrict the select range. The stimulus drives inputs only on falling edges, sweeps every code including the two pass-through codes, and sets arbitrary flag bytes so that the pass-through of S, Z, P/V and C is visible. It also inserts idle cycles so that the hold behaviour is exercised between operations.

// File: rtl/rs_pkg.sv
// Shared definitions for the rotate/shift unit: operation codes and
// flag bit positions. Assumes an 8-bit data path and flag byte.
package rs_pkg;
    localparam int DW = 8;

    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_F5 = 5;
    localparam int FL_H  = 4;
    localparam int FL_F3 = 3;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    localparam int FL_C  = 0;

    typedef enum logic [3:0] {
        OP_RLC  = 4'd0,
        OP_RRC  = 4'd1,
        OP_RL   = 4'd2,
        OP_RR   = 4'd3,
        OP_SLA  = 4'd4,
        OP_SRA  = 4'd5,
        OP_SL1  = 4'd6,
        OP_SRL  = 4'd7,
        OP_RLCA = 4'd8,
        OP_RRCA = 4'd9,
        OP_RLA  = 4'd10,
        OP_RRA  = 4'd11,
        OP_RLD  = 4'd12,
        OP_RRD  = 4'd13,
        OP_PS0  = 4'd14,
        OP_PS1  = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        CLS_FULL = 2'd0,
        CLS_ACC  = 2'd1,
        CLS_NIB  = 2'd2,
        CLS_PASS = 2'd3
    } cls_e;
endpackage

// File: rtl/rs_shift_core.sv
// Eight-way rotate/shift of a W-bit value.
// The code picks the operation: rotate left/right, rotate through the
// carry left/right, or one of four shifts. Purely combinational.
// Assumes W >= 2.
module rs_shift_core #(
    parameter int W = 8
) (
    input  logic [2:0]   code,
    input  logic [W-1:0] val,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int MSB = W - 1;

    // Select the shifted value and the bit that leaves it.
    always_comb begin
        res  = val;
        cout = 1'b0;
        case (code)
            3'd0: begin res = {val[MSB-1:0], val[MSB]}; cout = val[MSB]; end
            3'd1: begin res = {val[0], val[MSB:1]};     cout = val[0];   end
            3'd2: begin res = {val[MSB-1:0], cin};      cout = val[MSB]; end
            3'd3: begin res = {cin, val[MSB:1]};        cout = val[0];   end
            3'd4: begin res = {val[MSB-1:0], 1'b0};     cout = val[MSB]; end
            3'd5: begin res = {val[MSB], val[MSB:1]};   cout = val[0];   end
            3'd6: begin res = {val[MSB-1:0], 1'b1};     cout = val[MSB]; end
            default: begin res = {1'b0, val[MSB:1]};    cout = val[0];   end
        endcase
    end
endmodule

// File: rtl/rs_nibble.sv
// Half-word rotation between the accumulator and a memory byte.
// dir=0 rotates left (acc low half <- mem high half); dir=1 rotates
// right. The high half of the accumulator is kept. Assumes an even W.
module rs_nibble #(
    parameter int W = 8
) (
    input  logic         dir,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] m_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] m_out
);
    localparam int HW = W / 2;

    logic [HW-1:0] a_hi, a_lo, m_hi, m_lo;
    assign a_hi = a_in[W-1:HW];
    assign a_lo = a_in[HW-1:0];
    assign m_hi = m_in[W-1:HW];
    assign m_lo = m_in[HW-1:0];

    // Route the four halves according to the direction.
    always_comb begin
        if (!dir) begin
            a_out = {a_hi, m_hi};
            m_out = {m_lo, a_lo};
        end else begin
            a_out = {a_hi, m_lo};
            m_out = {a_lo, m_hi};
        end
    end
endmodule

// File: rtl/rs_flags.sv
// Builds the new flag byte from a result byte and an operation class.
// Full forms rebuild every flag. Accumulator rotates keep S, Z and P/V.
// Nibble rotates keep C. Pass-through returns the incoming flags.
module rs_flags
    import rs_pkg::*;
(
    input  cls_e          cls,
    input  logic [DW-1:0] res,
    input  logic          cout,
    input  logic [7:0]    f_in,
    output logic [7:0]    f_out
);
    logic zero, even;
    assign zero = (res == '0);
    assign even = ~^res;

    // Assemble the flag byte field by field for the chosen class.
    always_comb begin
        f_out = f_in;
        if (cls != CLS_PASS) begin
            f_out[FL_F5] = res[5];
            f_out[FL_F3] = res[3];
            f_out[FL_H]  = 1'b0;
            f_out[FL_N]  = 1'b0;
            if (cls != CLS_ACC) begin
                f_out[FL_S]  = res[DW-1];
                f_out[FL_Z]  = zero;
                f_out[FL_PV] = even;
            end
            if (cls != CLS_NIB) begin
                f_out[FL_C] = cout;
            end
        end
    end
endmodule

// File: rtl/rot_shift_unit.sv
// Rotate/shift/nibble-rotate unit with registered outputs.
// Decodes a 4-bit select into an operation class, runs the shift core
// or the nibble rotator, and captures result, memory byte and flags one
// cycle after in_valid. Assumes the inputs are stable at the sampling edge.
module rot_shift_unit
    import rs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] acc,
    input  logic [7:0]    flags_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic [DW-1:0] mem_result,
    output logic [7:0]    flags_out
);
    cls_e          cls;
    logic [2:0]    sh_code;
    logic [DW-1:0] sh_val, sh_res, nb_a, nb_m;
    logic          sh_cout;
    logic [DW-1:0] nx_res, nx_mem;
    logic [7:0]    nx_flags;

    // Classify the select into the four operation families.
    always_comb begin
        if (!op_sel[3])               cls = CLS_FULL;
        else if (op_sel[3:2] == 2'b10) cls = CLS_ACC;
        else if (op_sel[1] == 1'b0)    cls = CLS_NIB;
        else                           cls = CLS_PASS;
    end

    assign sh_code = (cls == CLS_FULL) ? op_sel[2:0] : {1'b0, op_sel[1:0]};
    assign sh_val  = (cls == CLS_ACC) ? acc : operand;

    rs_shift_core #(.W(DW)) u_shift (
        .code (sh_code),
        .val  (sh_val),
        .cin  (flags_in[FL_C]),
        .res  (sh_res),
        .cout (sh_cout)
    );

    rs_nibble #(.W(DW)) u_nib (
        .dir   (op_sel[0]),
        .a_in  (acc),
        .m_in  (operand),
        .a_out (nb_a),
        .m_out (nb_m)
    );

    // Pick the byte results for the selected family.
    always_comb begin
        nx_mem = operand;
        case (cls)
            CLS_NIB:  begin nx_res = nb_a; nx_mem = nb_m; end
            CLS_PASS: nx_res = operand;
            default:  nx_res = sh_res;
        endcase
    end

    rs_flags u_flags (
        .cls   (cls),
        .res   (nx_res),
        .cout  (sh_cout),
        .f_in  (flags_in),
        .f_out (nx_flags)
    );

    // Capture the outputs on a valid input; hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            mem_result <= '0;
            flags_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= nx_res;
                mem_result <= nx_mem;
                flags_out  <= nx_flags;
            end
        end
    end

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(mem_result) && $stable(flags_out)));

    // R3
    full_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel[3]) |=>
        (flags_out[FL_PV] == ~^result && flags_out[FL_Z] == (result == '0)
         && !flags_out[FL_H] && !flags_out[FL_N]));

    // R4
    acc_keep_szp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[3:2] == 2'b10) |=>
        (flags_out[FL_S] == $past(flags_in[FL_S]) && flags_out[FL_Z] == $past(flags_in[FL_Z])
         && flags_out[FL_PV] == $past(flags_in[FL_PV])));

    // R7
    nib_keep_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[3:1] == 3'b110) |=>
        (flags_out[FL_C] == $past(flags_in[FL_C]) && flags_out[FL_PV] == ~^result));

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[3:1] == 3'b111) |=>
        (result == $past(operand) && flags_out == $past(flags_in)
         && mem_result == $past(operand)));
endmodule

// File: tb/test_rot_shift_unit.sv
module test_rot_shift_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] operand = '0, acc = '0, flags_in = '0;
    logic       out_valid;
    logic [7:0] result, mem_result, flags_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int exp_r = 0, exp_m = 0, exp_f = 0;

    always #10 clk = ~clk;

    rot_shift_unit i_rot_shift_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .operand(operand), .acc(acc), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .mem_result(mem_result),
        .flags_out(flags_out)
    );

    function automatic int even_par(input int x);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (x >> i) & 1;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    function automatic int full_fl(input int r, input int co);
        return (r & 128) | ((r == 0) ? 64 : 0) | (r & 'h28) | (even_par(r) ? 4 : 0) | co;
    endfunction

    // Reference model written from the requirements.
    task automatic model(input int op, input int v, input int a, input int f,
                         output int r, output int m, output int fo);
        int x, k, c, co;
        c = f & 1; co = 0; r = v; m = v; fo = f;
        if (op < 12) begin
            x = (op < 8) ? v : a;
            k = op % 8;
            case (k)
                0: begin co = x >> 7; r = ((x << 1) | co) & 255; end
                1: begin co = x & 1;  r = (x >> 1) | (co << 7); end
                2: begin co = x >> 7; r = ((x << 1) | c) & 255; end
                3: begin co = x & 1;  r = (x >> 1) | (c << 7); end
                4: begin co = x >> 7; r = (x << 1) & 255; end
                5: begin co = x & 1;  r = (x >> 1) | (x & 128); end
                6: begin co = x >> 7; r = ((x << 1) | 1) & 255; end
                default: begin co = x & 1; r = x >> 1; end
            endcase
            if (op < 8) fo = full_fl(r, co);
            else        fo = (f & 'hC4) | (r & 'h28) | co;
        end else if (op == 12) begin
            r = (a & 'hF0) | (v >> 4);
            m = ((v << 4) & 'hF0) | (a & 'h0F);
            fo = (full_fl(r, 0) & 'hFE) | c;
        end else if (op == 13) begin
            r = (a & 'hF0) | (v & 'h0F);
            m = ((a & 'h0F) << 4) | (v >> 4);
            fo = (full_fl(r, 0) & 'hFE) | c;
        end
    endtask

    function automatic string tag_of(input int op);
        if (op < 4)  return "R1";
        if (op < 8)  return "R2";
        if (op < 12) return "R4";
        if (op == 12) return "R5";
        if (op == 13) return "R6";
        return "R8";
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Drive one cycle at a falling edge, then check at the next falling edge.
    task automatic step(input bit v, input int op, input int opd, input int a, input int f);
        string t;
        in_valid = v; op_sel = op[3:0]; operand = opd[7:0]; acc = a[7:0]; flags_in = f[7:0];
        if (v) model(op, opd, a, f, exp_r, exp_m, exp_f);
        @(posedge clk);
        @(negedge clk);
        t = v ? tag_of(op) : "R9";
        chk("R9 out_valid", int'(out_valid), int'(v));
        chk(t, int'(result), exp_r);
        chk((v && op >= 12 && op <= 13) ? t : (v ? "R8 mem" : "R9"), int'(mem_result), exp_m);
        if (v && op < 8)                 chk("R3", int'(flags_out), exp_f);
        else if (v && op >= 12 && op <= 13) chk("R7", int'(flags_out), exp_f);
        else                             chk(t, int'(flags_out), exp_f);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R10 reset state
        chk("R10", int'(out_valid), 0);
        chk("R10", int'(result), 0);
        chk("R10", int'(mem_result), 0);
        chk("R10", int'(flags_out), 0);
        rst_n = 1'b1;
        // R1 rotates
        step(1, 0, 'h80, 0, 0);
        step(1, 1, 'h01, 0, 0);
        step(1, 2, 'h80, 0, 1);
        step(1, 2, 'h00, 0, 1);
        step(1, 3, 'h01, 0, 0);
        step(1, 3, 'h02, 0, 1);
        // R2 shifts
        step(1, 4, 'h80, 0, 'hFF);
        step(1, 5, 'h81, 0, 0);
        step(1, 6, 'h00, 0, 0);
        step(1, 7, 'h01, 0, 'hFF);
        // R9 hold
        step(0, 0, 'h55, 'h55, 'h55);
        step(0, 7, 'hAA, 0, 0);
        // R4 accumulator rotates keep S, Z, P/V
        step(1, 8, 'h00, 'h81, 'hC4);
        step(1, 9, 'hFF, 'h01, 'h00);
        step(1, 10, 'h00, 'h80, 'h45);
        step(1, 11, 'h00, 'h01, 'h80);
        // R5, R6, R7 nibble rotates
        step(1, 12, 'h34, 'h12, 'h00);
        step(1, 13, 'h34, 'h12, 'h01);
        step(1, 12, 'h0F, 'h00, 'hFF);
        step(1, 13, 'hF0, 'h80, 'h00);
        // R8 pass-through codes
        step(1, 14, 'h5A, 'h11, 'hA5);
        step(1, 15, 'h00, 'hFF, 'h3C);
        // Mixed sweep with idle gaps
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 5) != 0, $urandom % 16, $urandom % 256,
                 $urandom % 256, $urandom % 256);
        end
        // R10 synchronous reset mid-run
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R10", int'(out_valid), 0);
        chk("R10", int'(result), 0);
        chk("R10", int'(flags_out), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule